// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches two independent ports, left and right, that share one memory array. Each port presents a chip enable, a write strobe and an address every clock. When both enabled ports point at the same address, the block decides which port owns the location. It pulls an active-low busy flag low toward the other port, and it suppresses that port's write strobe so the write never reaches the array. Reads are not blocked, because the block only ever touches write strobes.

Ownership goes to the port that got there first. A port counts as settled when it was enabled on the same address in the previous cycle. When both ports arrive in the same cycle, a fixed tie-break parameter names the winner. The winner is kept in a register for as long as the contention lasts without a break. A mode input chooses the source of busy. In master mode the block computes busy and drives it. In slave mode the busy flags come from an external master through two inputs, and the block only applies them to the write strobes.

Top module: `dpa_arb_top`

## Requirements
- R1: While reset is held and in the cycles after it with no contention, both busy outputs are high. Reset clears the arrival history, so two ports that engage in the first cycle after reset form a tie.
- R2: A busy output goes low only when both chip enables are high and the two addresses are equal.
- R3: A port is settled when its chip enable was high in the previous cycle with the same address it has now. When contention begins and exactly one port is settled, the other port's busy goes low in that same cycle.
- R4: When contention begins with both ports settled or neither settled, the port named by the tie-break loses: the right port with TIE_LEFT=1, the left port with TIE_LEFT=0.
- R5: While contention continues from one cycle to the next, the owner does not change, even if both addresses move together.
- R6: Busy is released in the same cycle that contention ends, whether the addresses stop matching or either chip enable drops.
- R7: The two busy outputs are never low in the same cycle.
- R8: In master mode each gated write strobe equals write strobe AND chip enable AND busy output. The loser's write is suppressed and the winner's write passes.
- R9: In slave mode (is_master low) both busy outputs stay high and no owner is tracked. Each gated write strobe equals write strobe AND chip enable AND that port's active-low busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1: busy is computed here; 0: busy comes from the inputs |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write strobe, active high |
| l_addr | input | ADDR_W | Left address |
| l_busy_in_n | input | 1 | Left busy from an external master, active low (slave mode) |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write strobe, active high |
| r_addr | input | ADDR_W | Right address |
| r_busy_in_n | input | 1 | Right busy from an external master, active low (slave mode) |
| l_busy_n | output | 1 | Busy toward the left port, active low |
| r_busy_n | output | 1 | Busy toward the right port, active low |
| l_we_gated | output | 1 | Left write strobe after gating, toward the array |
| r_we_gated | output | 1 | Right write strobe after gating, toward the array |

## Verification
The bench builds the block with ADDR_W=4 and TIE_LEFT=1, which makes the right port the loser of every tie. In the random phase, addresses are drawn from only four values. That makes matches, staggered arrivals, same-cycle arrivals and addresses moving together frequent enough that ownership hand-over and release occur hundreds of times. Mode flips in the middle of a match check that slave mode drops the owner and that re-entering master mode starts a fresh arbitration.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NPORT  = 2;
    localparam int P_LEFT = 0;
    localparam int P_RGHT = 1;
endpackage

// File: rtl/dpa_port_track.sv
// Remembers one port's enable and address from the previous cycle and
// reports whether the port is settled on its current address.
module dpa_port_track #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    typedef struct packed {
        logic              ce;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.ce   = ce;
        trk_d.addr = addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign settled = ce && trk_q.ce && (trk_q.addr == addr);
endmodule

// File: rtl/dpa_owner_fsm.sv
// Holds the owner of a contended address; chooses one when contention starts.
module dpa_owner_fsm
    import dpa_pkg::*;
#(
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   is_master,
    input  logic   contend,
    input  logic   l_settled,
    input  logic   r_settled,
    output owner_e owner_now
);
    localparam owner_e TIE_OWNER = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;

    typedef struct packed {
        owner_e own;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!is_master || !contend) begin
            st_d.own = OWN_NONE;
        end else if (st_q.own == OWN_NONE) begin
            if (l_settled && !r_settled)      st_d.own = OWN_LEFT;
            else if (r_settled && !l_settled) st_d.own = OWN_RIGHT;
            else                              st_d.own = TIE_OWNER;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.own <= OWN_NONE;
        else        st_q     <= st_d;
    end

    assign owner_now = st_d.own;
endmodule

// File: rtl/dpa_write_gate.sv
// Passes a write strobe only for an enabled port that is not held off.
module dpa_write_gate (
    input  logic we,
    input  logic ce,
    input  logic hold_off,
    output logic we_out
);
    assign we_out = we && ce && !hold_off;
endmodule

// File: rtl/dpa_arb_top.sv
module dpa_arb_top
    import dpa_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_in_n,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_we_gated,
    output logic              r_we_gated
);
    localparam int NP = NPORT;

    logic [NP-1:0]     ce_v, we_v, settled_v, busy_ext_v, hold_v, wg_v, busy_int_v;
    logic [ADDR_W-1:0] addr_v [NP];
    logic              contend;
    owner_e            owner;

    assign ce_v[P_LEFT]       = l_ce;
    assign ce_v[P_RGHT]       = r_ce;
    assign we_v[P_LEFT]       = l_we;
    assign we_v[P_RGHT]       = r_we;
    assign addr_v[P_LEFT]     = l_addr;
    assign addr_v[P_RGHT]     = r_addr;
    assign busy_ext_v[P_LEFT] = !l_busy_in_n;
    assign busy_ext_v[P_RGHT] = !r_busy_in_n;

    assign contend = l_ce && r_ce && (l_addr == r_addr);

    for (genvar gp = 0; gp < NP; gp++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (ce_v[gp]),
            .addr    (addr_v[gp]),
            .settled (settled_v[gp])
        );

        assign hold_v[gp] = is_master ? busy_int_v[gp] : busy_ext_v[gp];

        dpa_write_gate u_gate (
            .we       (we_v[gp]),
            .ce       (ce_v[gp]),
            .hold_off (hold_v[gp]),
            .we_out   (wg_v[gp])
        );
    end

    dpa_owner_fsm #(.TIE_LEFT(TIE_LEFT)) u_own (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .contend   (contend),
        .l_settled (settled_v[P_LEFT]),
        .r_settled (settled_v[P_RGHT]),
        .owner_now (owner)
    );

    assign busy_int_v[P_LEFT] = (owner == OWN_RIGHT);
    assign busy_int_v[P_RGHT] = (owner == OWN_LEFT);

    assign l_busy_n   = !busy_int_v[P_LEFT];
    assign r_busy_n   = !busy_int_v[P_RGHT];
    assign l_we_gated = wg_v[P_LEFT];
    assign r_we_gated = wg_v[P_RGHT];
endmodule

// File: rtl/dpa_arb_chk.sv
module dpa_arb_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              l_ce,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_in_n,
    input logic              r_ce,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_we_gated,
    input logic              r_we_gated
);
    logic match;
    assign match = l_ce && r_ce && (l_addr == r_addr);

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (l_busy_n && r_busy_n));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && match && $past(is_master && match && !r_busy_n)) |-> !r_busy_n);

    p_gate_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !l_busy_n) |-> !l_we_gated);

    p_gate_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !r_busy_n) |-> !r_we_gated);

    p_pass_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && l_ce && l_we && l_busy_n) |-> l_we_gated);

    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (l_busy_n && r_busy_n));

    p_slave_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && l_ce && l_we) |-> (l_we_gated == l_busy_in_n));

    p_slave_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && r_ce && r_we) |-> (r_we_gated == r_busy_in_n));
endmodule

bind dpa_arb_top dpa_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .is_master   (is_master),
    .l_ce        (l_ce),
    .l_we        (l_we),
    .l_addr      (l_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_ce        (r_ce),
    .r_we        (r_we),
    .r_addr      (r_addr),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_we_gated  (l_we_gated),
    .r_we_gated  (r_we_gated)
);

// File: tb/test_dpa_arb_top.sv
`timescale 1ns/1ps
module test_dpa_arb_top;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1;
    logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    logic l_busy_in_n = 1, r_busy_in_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_busy_n, r_busy_n, l_we_gated, r_we_gated;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state: 0 none, 1 left owns, 2 right owns
    int m_owner = 0;
    bit p_lce = 0, p_rce = 0;
    int p_la = 0, p_ra = 0;

    always #2 clk = ~clk;

    dpa_arb_top #(.ADDR_W(AW), .TIE_LEFT(1'b1)) i_dpa_arb_top (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_we_gated(l_we_gated), .r_we_gated(r_we_gated)
    );

    task automatic expect_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int next_owner();
        bit hit;
        bit ls, rs;
        hit = l_ce && r_ce && (int'(l_addr) == int'(r_addr));
        if (!is_master || !hit) return 0;
        if (m_owner != 0) return m_owner;
        ls = l_ce && p_lce && (p_la == int'(l_addr));
        rs = r_ce && p_rce && (p_ra == int'(r_addr));
        if (ls && !rs) return 1;
        if (rs && !ls) return 2;
        return 1; // tie: left keeps access
    endfunction

    // compare at the falling edge, advance the model at the rising edge
    task automatic step(string tag);
        int no;
        logic eb_l, eb_r, eg_l, eg_r;
        @(negedge clk);
        no   = next_owner();
        eb_l = !(is_master && no == 2);
        eb_r = !(is_master && no == 1);
        eg_l = l_we && l_ce && (is_master ? eb_l : l_busy_in_n);
        eg_r = r_we && r_ce && (is_master ? eb_r : r_busy_in_n);
        expect_bit(tag, "l_busy_n", l_busy_n, eb_l);
        expect_bit(tag, "r_busy_n", r_busy_n, eb_r);
        expect_bit(tag, "l_we_gated", l_we_gated, eg_l);
        expect_bit(tag, "r_we_gated", r_we_gated, eg_r);
        expect_bit("R7", "busy pair not both low", (!l_busy_n && !r_busy_n), 1'b0);
        @(posedge clk);
        m_owner = no;
        p_lce = l_ce; p_la = int'(l_addr);
        p_rce = r_ce; p_ra = int'(r_addr);
        #1;
    endtask

    task automatic drive(logic lc, logic lw, int la, logic rc, logic rw, int ra);
        l_ce = lc; l_we = lw; l_addr = AW'(la);
        r_ce = rc; r_we = rw; r_addr = AW'(ra);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        expect_bit("R1", "l_busy_n in reset", l_busy_n, 1'b1);
        expect_bit("R1", "r_busy_n in reset", r_busy_n, 1'b1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step("R1");

        // R1/R4: both engage in the first cycle after reset -> tie, right loses
        drive(1, 1, 6, 1, 1, 6);
        step("R4");
        drive(0, 0, 0, 0, 0, 0);
        step("R6");

        // R2: different addresses, or one port disabled
        drive(1, 1, 3, 1, 1, 5);
        step("R2");
        drive(1, 1, 5, 0, 1, 5);
        step("R2");
        drive(0, 0, 0, 0, 0, 0);
        step("R2");

        // R3: left first, right joins later -> right busy, right write gated
        drive(1, 0, 7, 0, 0, 0);
        step("R3");
        drive(1, 1, 7, 1, 1, 7);
        step("R3");
        // R5: hold, including both addresses moving together
        step("R5");
        drive(1, 1, 9, 1, 1, 9);
        step("R5");
        step("R8");
        // R6: release on mismatch
        drive(1, 1, 9, 1, 1, 8);
        step("R6");
        drive(0, 0, 0, 0, 0, 0);
        step("R6");

        // R3: right first, left joins -> left busy
        drive(0, 0, 0, 1, 0, 11);
        step("R3");
        drive(1, 1, 11, 1, 1, 11);
        step("R3");
        step("R8");
        // R6: winner (right) drops enable -> left released same cycle
        drive(1, 1, 11, 0, 0, 11);
        step("R6");
        drive(0, 0, 0, 0, 0, 0);
        step("R6");

        // R4: both settled-less arrival in the same cycle
        drive(1, 0, 2, 1, 1, 2);
        step("R4");
        step("R5");
        drive(0, 0, 0, 0, 0, 0);
        step("R6");

        // R9: slave mode
        is_master = 1'b0;
        drive(1, 1, 4, 1, 1, 4);
        l_busy_in_n = 1'b0; r_busy_in_n = 1'b1;
        step("R9");
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
        step("R9");
        is_master = 1'b1;
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        step("R4");
        drive(0, 0, 0, 0, 0, 0);
        step("R6");

        // random phase over a small address window
        for (int i = 0; i < 600; i++) begin
            is_master   = ($urandom_range(0, 9) != 0);
            l_busy_in_n = ($urandom_range(0, 2) != 0);
            r_busy_in_n = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 2) == 0)
                drive($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                      r_ce, 1'($urandom_range(0, 1)), int'(r_addr));
            if ($urandom_range(0, 2) == 0)
                drive(l_ce, l_we, int'(l_addr),
                      $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), $urandom_range(0, 3));
            step("R3");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule